// File: doc/BRIEF.md
# Per-Core DC Offset Corrector Bank

This block sits behind a four-way time-interleaved analog-to-digital converter. Each of the four sub-converter cores delivers its own sample stream at one quarter of the combined rate. Every core's stream goes through its own corrector. The corrector keeps a slowly moving estimate of how far that stream's average sits from mid-code (zero in two's complement) and subtracts that estimate from each sample, so each lane behaves as a high-pass filter. Correcting every core separately, before the lanes are merged, removes the constant term and the tones at one quarter and one half of the combined sample rate that offset mismatch between cores would otherwise create.

Each lane has its own 8-bit control byte. The byte selects one of three modes (running, frozen or bypassed) and sets the estimator bandwidth. A shared magnitude limit models the finite correction range. The four corrected lanes are merged round-robin in fixed core order into one output stream, one output word per lane sample, and each word is tagged with the index of the core it came from.

A typical use is calibration. The analog input is left idle while the lanes run and settle on the cores' internal offsets. The lanes are then frozen, so the learned offsets keep being removed once real signal is applied.

Top module: `dcoc_bank`

## Requirements
- R1: A synchronous active-high reset clears every lane's estimate to zero and all pending lane data, and out_valid stays low while reset is applied. The first sample after reset therefore leaves the block unchanged.
- R2: In running mode (control bit 7 = 0 and bit 2 = 0), each valid sample x updates the estimate E, which is held with 8 fractional bits: E <= E + ((x·2^8 − E) >>> k). The shift k is the 3-bit field in control bits 6:4, plus one. The right shift is arithmetic, so it floors.
- R3: A lane's output is x minus floor(E / 2^8), saturated to the 14-bit two's-complement range [−8192, 8191] instead of wrapping. The subtraction uses the estimate held before the update.
- R4: In frozen mode (control bit 7 = 1, bit 2 = 0), the estimate does not change, but it is still subtracted from every sample.
- R5: In bypass mode (control bit 2 = 1, whatever the value of bit 7), the lane outputs x unchanged and its estimate is retained unchanged.
- R6: When a lane leaves bypass, it resumes subtracting the retained estimate, without any reset of that estimate.
- R7: After each update, the estimate is clamped to the range ±est_limit·2^8, where est_limit is an unsigned 13-bit magnitude.
- R8: Output words come out in core order 0, 1, 2, 3, 0, …. There is exactly one output word per valid lane sample, and out_core carries the index of the source core.
- R9: An estimate changes only on a cycle where its lane's in_valid is high. Idle cycles leave every lane's estimate unchanged.
- R10: Each lane's control byte affects only that lane's output and estimate.
- R11: With a constant input and k = 1, a running lane's output converges to within ±1 of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the combined (output) sample rate |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 32 | Four control bytes; bits 8i+7..8i belong to lane i (bit 7 freeze, bits 6:4 bandwidth, bit 2 bypass, bit 1 reserved and written as 1) |
| est_limit | input | 13 | Largest magnitude allowed for the integer part of any estimate |
| in_valid | input | 4 | Per-lane sample strobe, at most one every four cycles per lane |
| in_data | input | 56 | Four 14-bit two's-complement samples; bits 14i+13..14i belong to lane i |
| out_valid | output | 1 | Interleaved output word valid |
| out_core | output | 2 | Index of the core that produced the current output word |
| out_data | output | 14 | Corrected two's-complement sample |

## Verification
The lanes first receive non-zero samples straight after reset, which shows whether the estimate starts at zero. Constant per-lane offsets are then applied with a different bandwidth on each lane. This separates the four shift values and shows convergence on the fastest setting. Patterns that change value while lanes are frozen or bypassed show whether the held estimate is still subtracted, or dropped, and the first frame after bypass is released shows whether the estimate was retained. Near-full-scale offsets followed by opposite full-scale inputs drive the subtraction past both rails. A small limit under a large constant input shows the estimate clamp, and long idle gaps between frames show that estimates move only on valid samples.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;

    // Control byte field positions (one byte per lane)
    localparam int FRZ_BIT = 7;
    localparam int BYP_BIT = 2;
    localparam int BW_LSB  = 4;
    localparam int BW_W    = 3;

    typedef enum logic [1:0] {
        LM_RUN    = 2'd0,
        LM_FREEZE = 2'd1,
        LM_BYPASS = 2'd2
    } lane_mode_e;

    typedef struct packed {
        lane_mode_e  mode;
        logic [3:0]  shift;
    } lane_cfg_t;

    // Bypass takes priority over freeze
    function automatic lane_cfg_t decode_ctrl(input logic [7:0] c);
        lane_cfg_t r;
        if (c[BYP_BIT])      r.mode = LM_BYPASS;
        else if (c[FRZ_BIT]) r.mode = LM_FREEZE;
        else                 r.mode = LM_RUN;
        r.shift = 4'(c[BW_LSB +: BW_W]) + 4'd1;
        return r;
    endfunction

endpackage

// File: rtl/dcoc_lane.sv
module dcoc_lane
    import dcoc_pkg::*;
#(
    parameter int DW = 14,
    parameter int FW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           ctrl,
    input  logic [DW-2:0]        limit,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    input  logic                 take,
    output logic                 pend,
    output logic [DW-1:0]        dat,
    output logic [DW+FW-1:0]     est_q
);
    localparam int EW = DW + FW;

    lane_cfg_t cfg;
    assign cfg = decode_ctrl(ctrl);

    logic signed [EW-1:0] est;
    logic signed [EW:0]   x_ext, e_ext, diff, step, sum, lim_hi, lim_lo;
    logic signed [EW-1:0] upd;
    logic signed [DW-1:0] est_int;
    logic signed [DW:0]   corr;
    logic        [DW-1:0] dat_nx;

    localparam logic signed [DW:0] SMAX = $signed({2'b00, {(DW-1){1'b1}}});
    localparam logic signed [DW:0] SMIN = $signed({2'b11, {(DW-1){1'b0}}});

    // Leaky accumulator update with magnitude clamp
    always_comb begin
        x_ext  = $signed({in_data[DW-1], in_data, {FW{1'b0}}});
        e_ext  = $signed({est[EW-1], est});
        diff   = x_ext - e_ext;
        step   = diff >>> cfg.shift;
        sum    = e_ext + step;
        lim_hi = $signed({2'b00, limit, {FW{1'b0}}});
        lim_lo = -lim_hi;
        if (sum > lim_hi)      upd = lim_hi[EW-1:0];
        else if (sum < lim_lo) upd = lim_lo[EW-1:0];
        else                   upd = sum[EW-1:0];
    end

    // Subtract integer part of estimate, saturate
    always_comb begin
        est_int = est[EW-1:FW];
        corr    = $signed({in_data[DW-1], in_data}) - $signed({est_int[DW-1], est_int});
        if (cfg.mode == LM_BYPASS) dat_nx = in_data;
        else if (corr > SMAX)      dat_nx = SMAX[DW-1:0];
        else if (corr < SMIN)      dat_nx = SMIN[DW-1:0];
        else                       dat_nx = corr[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            est  <= '0;
            pend <= 1'b0;
            dat  <= '0;
        end else if (in_valid) begin
            dat  <= dat_nx;
            pend <= 1'b1;
            if (cfg.mode == LM_RUN) est <= upd;
        end else if (take) begin
            pend <= 1'b0;
        end
    end

    assign est_q = est;

endmodule

// File: rtl/dcoc_merge.sv
module dcoc_merge #(
    parameter int NL = 4,
    parameter int DW = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NL-1:0]            pend,
    input  logic [NL-1:0][DW-1:0]    dat,
    output logic [NL-1:0]            take,
    output logic                     out_valid,
    output logic [$clog2(NL)-1:0]    out_core,
    output logic [DW-1:0]            out_data
);
    localparam int CL = $clog2(NL);

    logic [CL-1:0] ptr;

    always_comb begin
        take = '0;
        take[ptr] = pend[ptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            out_valid <= 1'b0;
            out_core  <= '0;
            out_data  <= '0;
        end else if (pend[ptr]) begin
            out_valid <= 1'b1;
            out_core  <= ptr;
            out_data  <= dat[ptr];
            ptr       <= (ptr == CL'(NL-1)) ? '0 : ptr + 1'b1;
        end else begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dcoc_bank.sv
module dcoc_bank
    import dcoc_pkg::*;
#(
    parameter int NL = 4,
    parameter int DW = 14,
    parameter int FW = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NL*8-1:0]         ctrl,
    input  logic [DW-2:0]           est_limit,
    input  logic [NL-1:0]           in_valid,
    input  logic [NL*DW-1:0]        in_data,
    output logic                    out_valid,
    output logic [$clog2(NL)-1:0]   out_core,
    output logic [DW-1:0]           out_data
);
    localparam int EW = DW + FW;

    logic [NL-1:0]          lane_pend;
    logic [NL-1:0]          lane_take;
    logic [NL-1:0][DW-1:0]  lane_dat;
    logic [NL-1:0][EW-1:0]  est_all;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        dcoc_lane #(.DW(DW), .FW(FW)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (ctrl[i*8 +: 8]),
            .limit    (est_limit),
            .in_valid (in_valid[i]),
            .in_data  (in_data[i*DW +: DW]),
            .take     (lane_take[i]),
            .pend     (lane_pend[i]),
            .dat      (lane_dat[i]),
            .est_q    (est_all[i])
        );
    end

    dcoc_merge #(.NL(NL), .DW(DW)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .pend      (lane_pend),
        .dat       (lane_dat),
        .take      (lane_take),
        .out_valid (out_valid),
        .out_core  (out_core),
        .out_data  (out_data)
    );

endmodule

// File: rtl/dcoc_chk.sv
module dcoc_chk #(
    parameter int NL = 4,
    parameter int DW = 14,
    parameter int EW = 22
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NL*8-1:0]        ctrl,
    input logic [NL-1:0]          in_valid,
    input logic [NL*DW-1:0]       in_data,
    input logic                   out_valid,
    input logic [$clog2(NL)-1:0]  out_core,
    input logic [NL-1:0][DW-1:0]  lane_dat,
    input logic [NL-1:0][EW-1:0]  est_all
);
    localparam int CL = $clog2(NL);

    logic [CL-1:0] exp_core;
    always_ff @(posedge clk) begin
        if (rst)            exp_core <= '0;
        else if (out_valid) exp_core <= (exp_core == CL'(NL-1)) ? '0 : exp_core + 1'b1;
    end

    // R1: no output while in reset
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !out_valid);

    // R8: cores appear in fixed rotating order
    p_core_order_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_core == exp_core);

    for (genvar i = 0; i < NL; i++) begin : g_lane_chk
        // R5: bypassed sample passes unchanged
        p_bypass_raw_r5: assert property (@(posedge clk) disable iff (rst)
            (in_valid[i] && ctrl[i*8+2]) |=> lane_dat[i] == $past(in_data[i*DW +: DW]));

        // R4: frozen (or bypassed) lane keeps its estimate
        p_frozen_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (ctrl[i*8+7] || ctrl[i*8+2]) |=> est_all[i] == $past(est_all[i]));

        // R9: estimate moves only on valid samples
        p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
            !in_valid[i] |=> $stable(est_all[i]));
    end

endmodule

bind dcoc_bank dcoc_chk #(.NL(NL), .DW(DW), .EW(EW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_core  (out_core),
    .lane_dat  (lane_dat),
    .est_all   (est_all)
);

// File: tb/sim_dcoc_bank.sv
module sim_dcoc_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int DW = 14;
    localparam int FW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NL*8-1:0]   ctrl;
    logic [DW-2:0]     est_limit = 13'd8191;
    logic [NL-1:0]     in_valid = '0;
    logic [NL*DW-1:0]  in_data = '0;
    logic              out_valid;
    logic [1:0]        out_core;
    logic [DW-1:0]     out_data;

    logic [7:0] cbyte [NL];
    always_comb ctrl = {cbyte[3], cbyte[2], cbyte[1], cbyte[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    dcoc_bank #(.NL(NL), .DW(DW), .FW(FW)) u0 (
        .clk(clk), .rst(rst), .ctrl(ctrl), .est_limit(est_limit),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_core(out_core), .out_data(out_data)
    );

    int     n_checks = 0;
    int     n_errors = 0;
    string  cur_tag  = "R1";
    longint est [NL];
    int     q_core [$];
    int     q_data [$];
    int     last_out [NL];

    function automatic longint sat(input longint v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: one frame = one valid cycle + three idle cycles
    task automatic send(input int x0, input int x1, input int x2, input int x3);
        int xs [NL];
        xs = '{x0, x1, x2, x3};
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            longint ei, ev, d, lim;
            bit byp, frz;
            int k;
            in_data[l*DW +: DW] = xs[l][DW-1:0];
            byp = cbyte[l][2];
            frz = cbyte[l][7];
            k   = int'(cbyte[l][6:4]) + 1;
            ei  = est[l] >>> FW;
            ev  = byp ? longint'(xs[l]) : sat(longint'(xs[l]) - ei);
            if (!byp && !frz) begin
                lim = longint'(est_limit) <<< FW;
                d   = (longint'(xs[l]) <<< FW) - est[l];
                est[l] = est[l] + (d >>> k);
                if (est[l] > lim)  est[l] = lim;
                if (est[l] < -lim) est[l] = -lim;
            end
            q_core.push_back(l);
            q_data.push_back(int'(ev));
        end
        in_valid = '1;
        @(negedge clk);
        in_valid = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_core.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R8: actual=unexpected output expected=none");
            end else begin
                int ec, ed;
                ec = q_core.pop_front();
                ed = q_data.pop_front();
                check("R8 core order", longint'(out_core), longint'(ec));
                check(cur_tag, longint'($signed(out_data)), longint'(ed));
                last_out[out_core] = int'($signed(out_data));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) begin cbyte[l] = 8'h02; est[l] = 0; end
        repeat (5) @(negedge clk);
        check("R1 reset out_valid", longint'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", longint'(out_valid), 0);

        // R1: estimate starts at zero
        cur_tag = "R1";
        send(100, -200, 300, -400);

        // R2/R11: per-lane bandwidths, constant offsets
        cur_tag = "R2";
        cbyte[0] = 8'h02; cbyte[1] = 8'h12; cbyte[2] = 8'h32; cbyte[3] = 8'h72;
        for (int i = 0; i < 30; i++) send(40, -60, 25, -10);
        drain();
        n_checks++;
        if (last_out[0] > 1 || last_out[0] < -1) begin
            n_errors++;
            $display("FAIL R11: actual=%0d expected=within +-1", last_out[0]);
        end

        // R10: freeze lane 1 only
        cur_tag = "R10";
        cbyte[1] = 8'h82;
        for (int i = 0; i < 4; i++) send(-300, 500, -700, 900);

        // R4: all frozen, changing input
        cur_tag = "R4";
        for (int l = 0; l < NL; l++) cbyte[l] = 8'h82;
        send(1000, -1000, 2000, 0);
        send(-5, 7, 0, 3000);

        // R5: bypass (lane 2 with both bits set)
        cur_tag = "R5";
        cbyte[0] = 8'h06; cbyte[1] = 8'h06; cbyte[2] = 8'h86; cbyte[3] = 8'h06;
        send(123, -456, 789, -1011);
        send(8191, -8192, 0, 1);

        // R9: long idle gap then frozen frame
        cur_tag = "R9";
        for (int l = 0; l < NL; l++) cbyte[l] = 8'h82;
        repeat (20) @(negedge clk);
        send(0, 0, 0, 0);

        // R6: release to running
        cur_tag = "R6";
        for (int l = 0; l < NL; l++) cbyte[l] = 8'h02;
        send(50, 50, 50, 50);
        drain();

        // R1: mid-run reset clears estimates
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int l = 0; l < NL; l++) est[l] = 0;
        cur_tag = "R1";
        send(77, -77, 0, 5);

        // R3: saturation at both rails
        cur_tag = "R3";
        for (int i = 0; i < 30; i++) send(8000, -8000, 0, 0);
        cbyte[0] = 8'h82; cbyte[1] = 8'h82;
        send(-8192, 8191, 0, 0);

        // R7: estimate clamp
        cur_tag = "R7";
        drain();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int l = 0; l < NL; l++) begin est[l] = 0; cbyte[l] = 8'h02; end
        est_limit = 13'd100;
        for (int i = 0; i < 20; i++) send(3000, -3000, 50, 0);
        for (int l = 0; l < NL; l++) cbyte[l] = 8'h82;
        send(0, 0, 0, 0);
        drain();

        check("R8 queue drained", longint'(q_core.size()), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule